// File: doc/BRIEF.md
# Fan PWM Generator with Timed Spin-Up

This block drives a fan through a single PWM pin. An 8-bit duty code sets the high fraction of each period. A 3-bit frequency code and a range input select the period. One range spans tens of hertz and the other spans kilohertz. The time base counts a 3.2 MHz clock, and each period length is derived from that clock rate at elaboration.

A start pulse launches a spin-up phase unless spin-up is disabled. During spin-up the pin is held high for a programmable number of seconds. When the phase ends, a fresh PWM period begins.

A minimum-duty rule applies when the tach-mode input is 0, and the rule depends on the control mode. In speed-regulation mode, a small duty is raised to about 30%. In the direct and automatic modes, a small duty is forced to zero. The readback output always shows the code that was calculated, never the clamped one. Duty, frequency, range and mode are sampled only at period boundaries, so a change never leaves a runt pulse on the pin.

Top module: `fan_pwm_gen`

## Requirements
- R1: While rst_ni is low, pwm_o is 0 and duty_rb_o is 0x55.
- R2: Frequency code 0..7 selects the period. With range_hz_i=1 the rates are 10, 15, 23, 30, 38, 47, 62 and 94 Hz. With range_hz_i=0 the rates are 1, 10, 20, 25, 30, 40, 40 and 40 kHz. The period in cycles is round(CLK_HZ / rate), for example 80 cycles at 40 kHz and 34043 cycles at 94 Hz.
- R3: Each period starts with a high part of floor(period × effective_duty / 255) cycles, and the output is low for the rest of the period. Code 0xFF therefore keeps the pin high and code 0x00 keeps it low.
- R4: The duty code, frequency code, range select and mode inputs are taken only at a period boundary. An input change mid-period affects neither the current period nor duty_rb_o until the next boundary.
- R5: When start_i is sampled high with spin_dis_i=0, pwm_o is high from the next cycle for units × SPIN_UNIT_CYC cycles. The spin time code 0..7 selects 1, 2, 3, 4, 5, 10, 20 or 40 units, and one unit is 0.2 s at the default setting. A new PWM period starts at cycle 0 right after the phase ends.
- R6: When spin_dis_i=1, start_i has no effect on pwm_o, whatever the spin time code is.
- R7: With tach_mode_i=0 and mode_i=1 (speed regulation), a duty code below 77 is driven as 77, which is about 30%.
- R8: With tach_mode_i=0 and mode_i equal to 0 (direct), 2 (automatic) or 3, a duty code below 18 is driven as 0. A code below 18 is under 7%.
- R9: With tach_mode_i=1, no minimum-duty rule applies, and the effective duty equals the code.
- R10: duty_rb_o returns the duty code calculated at the last boundary, before any clamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | PWM time-base clock (3.2 MHz nominal) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| duty_i | input | 8 | Duty code, 0x00 = 0 %, 0xFF = 100 % |
| freq_sel_i | input | 3 | Frequency code within the selected range |
| range_hz_i | input | 1 | 1 = hertz range, 0 = kilohertz range |
| spin_time_i | input | 3 | Spin-up length code |
| spin_dis_i | input | 1 | 1 disables the spin-up phase |
| mode_i | input | 2 | 0 direct, 1 speed regulation, 2 automatic |
| tach_mode_i | input | 1 | 0 enables the minimum-duty rules |
| start_i | input | 1 | Start request, one cycle |
| pwm_o | output | 1 | Fan PWM pin |
| duty_rb_o | output | 8 | Calculated (unclamped) duty readback |

## Verification
The bench synchronises to the design by issuing a start with the shortest spin time. SPIN_UNIT_CYC is 2 in the bench, so pwm_o is high in exactly the two cycles after the edge that samples start_i, and the third cycle is cycle 0 of a fresh period. From there each result is due at a known cycle. duty_rb_o shows the new code at cycle 0. The high count of a period is totalled over cycles 0 to period-1. A duty change applied at cycle 0 first appears at cycle period, and the bench samples at that cycle. All samples are taken on the falling clock edge, half a cycle after the registers update.

// File: rtl/fan_pwm_pkg.sv
package fan_pwm_pkg;

  typedef enum logic [1:0] {
    MODE_DIRECT = 2'd0,
    MODE_RPM    = 2'd1,
    MODE_AUTO   = 2'd2,
    MODE_RSVD   = 2'd3
  } fan_mode_e;

  function automatic int unsigned freq_hz(input logic hz_range, input logic [2:0] code);
    int unsigned f;
    if (hz_range) begin
      case (code)
        3'd0: f = 10;
        3'd1: f = 15;
        3'd2: f = 23;
        3'd3: f = 30;
        3'd4: f = 38;
        3'd5: f = 47;
        3'd6: f = 62;
        default: f = 94;
      endcase
    end else begin
      case (code)
        3'd0: f = 1000;
        3'd1: f = 10000;
        3'd2: f = 20000;
        3'd3: f = 25000;
        3'd4: f = 30000;
        default: f = 40000;
      endcase
    end
    return f;
  endfunction

  // spin-up length in 0.2 s units
  function automatic int unsigned spin_units(input logic [2:0] code);
    int unsigned u;
    case (code)
      3'd0: u = 1;
      3'd1: u = 2;
      3'd2: u = 3;
      3'd3: u = 4;
      3'd4: u = 5;
      3'd5: u = 10;
      3'd6: u = 20;
      default: u = 40;
    endcase
    return u;
  endfunction

  function automatic int unsigned div_round(input int unsigned n, input int unsigned d);
    int unsigned q;
    q = (n + d / 2) / d;
    return (q == 0) ? 1 : q;
  endfunction

endpackage

// File: rtl/fan_pwm_period.sv
module fan_pwm_period
  import fan_pwm_pkg::*;
#(
  parameter int unsigned CLK_HZ = 3_200_000,
  parameter int unsigned PER_W  = 19
) (
  input  logic             range_hz_i,
  input  logic [2:0]       freq_sel_i,
  output logic [PER_W-1:0] per_o
);
  localparam int unsigned NUM_ENT = 16;

  logic [PER_W-1:0] tab [NUM_ENT];

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_tab
    localparam int unsigned TICKS = div_round(CLK_HZ, freq_hz(1'(g / 8), 3'(g % 8)));
    assign tab[g] = PER_W'(TICKS);
  end

  assign per_o = tab[{range_hz_i, freq_sel_i}];
endmodule

// File: rtl/fan_pwm_clamp.sv
module fan_pwm_clamp
  import fan_pwm_pkg::*;
#(
  parameter int unsigned RPM_MIN = 77,
  parameter int unsigned DIR_MIN = 18
) (
  input  logic [7:0] duty_i,
  input  fan_mode_e  mode_i,
  input  logic       tach_mode_i,
  output logic [7:0] eff_o
);
  always_comb begin
    eff_o = duty_i;
    if (!tach_mode_i) begin
      if (mode_i == MODE_RPM) begin
        if (duty_i < 8'(RPM_MIN)) eff_o = 8'(RPM_MIN);
      end else if (duty_i < 8'(DIR_MIN)) begin
        eff_o = 8'd0;
      end
    end
  end
endmodule

// File: rtl/fan_pwm_core.sv
module fan_pwm_core #(
  parameter int unsigned PER_W  = 19,
  parameter logic [7:0]  RB_RST = 8'h55
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [PER_W-1:0] per_new_i,
  input  logic [7:0]       eff_new_i,
  input  logic [7:0]       calc_new_i,
  output logic             load_o,
  output logic             pwm_o,
  output logic [7:0]       duty_rb_o
);
  localparam int unsigned PROD_W = PER_W + 8;

  logic [PER_W-1:0]  cnt_q, per_q, hi_q, hi_new;
  logic [PROD_W-1:0] prod;
  logic [7:0]        rb_q;

  assign prod   = PROD_W'(per_new_i) * PROD_W'(eff_new_i);
  assign hi_new = PER_W'(prod / PROD_W'(255));
  assign load_o = restart_i || (cnt_q == per_q - PER_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      per_q <= PER_W'(1);
      hi_q  <= '0;
      rb_q  <= RB_RST;
    end else if (load_o) begin
      cnt_q <= '0;
      per_q <= per_new_i;
      hi_q  <= hi_new;
      rb_q  <= calc_new_i;
    end else begin
      cnt_q <= cnt_q + PER_W'(1);
    end
  end

  assign pwm_o     = cnt_q < hi_q;
  assign duty_rb_o = rb_q;
endmodule

// File: rtl/fan_spinup.sv
module fan_spinup
  import fan_pwm_pkg::*;
#(
  parameter int unsigned UNIT_CYC = 640_000,
  parameter int unsigned SPIN_W   = 25
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       dis_i,
  input  logic [2:0] time_i,
  output logic       active_o
);
  logic [SPIN_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (start_i && !dis_i) begin
      cnt_q <= SPIN_W'(spin_units(time_i) * UNIT_CYC);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - SPIN_W'(1);
    end
  end

  assign active_o = cnt_q != '0;
endmodule

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen
  import fan_pwm_pkg::*;
#(
  parameter int unsigned CLK_HZ        = 3_200_000,
  parameter int unsigned SPIN_UNIT_CYC = 640_000,
  parameter int unsigned RPM_MIN       = 77,
  parameter int unsigned DIR_MIN       = 18
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] duty_i,
  input  logic [2:0] freq_sel_i,
  input  logic       range_hz_i,
  input  logic [2:0] spin_time_i,
  input  logic       spin_dis_i,
  input  logic [1:0] mode_i,
  input  logic       tach_mode_i,
  input  logic       start_i,
  output logic       pwm_o,
  output logic [7:0] duty_rb_o
);
  localparam int unsigned PER_W  = $clog2(CLK_HZ / 10 + 2);
  localparam int unsigned SPIN_W = $clog2(40 * SPIN_UNIT_CYC + 1);

  logic [PER_W-1:0] per_new;
  logic [7:0]       eff_duty;
  logic             spin_active, core_pwm, core_load;

  fan_pwm_period #(.CLK_HZ(CLK_HZ), .PER_W(PER_W)) u_period (
    .range_hz_i (range_hz_i),
    .freq_sel_i (freq_sel_i),
    .per_o      (per_new)
  );

  fan_pwm_clamp #(.RPM_MIN(RPM_MIN), .DIR_MIN(DIR_MIN)) u_clamp (
    .duty_i      (duty_i),
    .mode_i      (fan_mode_e'(mode_i)),
    .tach_mode_i (tach_mode_i),
    .eff_o       (eff_duty)
  );

  fan_spinup #(.UNIT_CYC(SPIN_UNIT_CYC), .SPIN_W(SPIN_W)) u_spin (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .dis_i    (spin_dis_i),
    .time_i   (spin_time_i),
    .active_o (spin_active)
  );

  // time base held at a boundary during spin-up so a full period follows it
  fan_pwm_core #(.PER_W(PER_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .restart_i  (spin_active),
    .per_new_i  (per_new),
    .eff_new_i  (eff_duty),
    .calc_new_i (duty_i),
    .load_o     (core_load),
    .pwm_o      (core_pwm),
    .duty_rb_o  (duty_rb_o)
  );

  assign pwm_o = spin_active | core_pwm;
endmodule

// File: rtl/fan_pwm_gen_chk.sv
module fan_pwm_gen_chk #(
  parameter int unsigned RPM_MIN = 77,
  parameter int unsigned DIR_MIN = 18
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] duty_i,
  input logic [1:0] mode_i,
  input logic       tach_mode_i,
  input logic       start_i,
  input logic       spin_dis_i,
  input logic       pwm_o,
  input logic [7:0] duty_rb_o,
  input logic       spin_active_i,
  input logic       load_i,
  input logic [7:0] eff_i
);
  assert_spin_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !spin_dis_i) |=> pwm_o);

  assert_spin_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spin_active_i |-> pwm_o);

  assert_spin_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && spin_dis_i && !spin_active_i) |=> !spin_active_i);

  assert_rb_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(duty_rb_o));

  assert_rpm_floor_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tach_mode_i && mode_i == 2'd1) |-> (eff_i >= 8'(RPM_MIN)));

  assert_low_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tach_mode_i && mode_i != 2'd1 && duty_i < 8'(DIR_MIN)) |-> (eff_i == 8'd0));

  assert_no_clamp_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tach_mode_i |-> (eff_i == duty_i));
endmodule

bind fan_pwm_gen fan_pwm_gen_chk #(.RPM_MIN(RPM_MIN), .DIR_MIN(DIR_MIN)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .duty_i        (duty_i),
  .mode_i        (mode_i),
  .tach_mode_i   (tach_mode_i),
  .start_i       (start_i),
  .spin_dis_i    (spin_dis_i),
  .pwm_o         (pwm_o),
  .duty_rb_o     (duty_rb_o),
  .spin_active_i (spin_active),
  .load_i        (core_load),
  .eff_i         (eff_duty)
);

// File: tb/fan_pwm_gen_tb.sv
module fan_pwm_gen_tb;
  localparam int unsigned CLK_HZ = 3_200_000;
  localparam int unsigned UNIT   = 2;

  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] duty = 8'h00;
  logic [2:0] fsel = 3'd0;
  logic       rng = 0;
  logic [2:0] stime = 3'd0;
  logic       sdis = 0;
  logic [1:0] mode = 2'd0;
  logic       tach = 1;
  logic       start = 0;
  logic       pwm;
  logic [7:0] rb;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  fan_pwm_gen #(.CLK_HZ(CLK_HZ), .SPIN_UNIT_CYC(UNIT)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .duty_i(duty), .freq_sel_i(fsel), .range_hz_i(rng),
    .spin_time_i(stime), .spin_dis_i(sdis), .mode_i(mode), .tach_mode_i(tach),
    .start_i(start), .pwm_o(pwm), .duty_rb_o(rb)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_per(input logic hz, input logic [2:0] s);
    int lo [8] = '{10, 15, 23, 30, 38, 47, 62, 94};
    int hi [8] = '{1000, 10000, 20000, 25000, 30000, 40000, 40000, 40000};
    int f;
    f = hz ? lo[s] : hi[s];
    return (CLK_HZ + f / 2) / f;
  endfunction

  function automatic int exp_eff(input int d, input logic [1:0] md, input logic tm);
    if (tm) return d;
    if (md == 2'd1) return (d < 77) ? 77 : d;
    return (d < 18) ? 0 : d;
  endfunction

  function automatic int exp_units(input int c);
    int u [8] = '{1, 2, 3, 4, 5, 10, 20, 40};
    return u[c];
  endfunction

  // sync with a 2-cycle spin-up, then measure two periods; duty switches to d2 at cycle 0
  task automatic run_per(input logic [7:0] d1, input logic [7:0] d2, input logic [1:0] md,
                         input logic tm, input logic hz, input logic [2:0] sel, input string tag);
    int per, h1, h2, cnt;
    @(negedge clk);
    duty = d1; mode = md; tach = tm; rng = hz; fsel = sel; sdis = 0; stime = 3'd0; start = 1;
    @(negedge clk);
    start = 0;
    chk(pwm == 1'b1, "R5", int'(pwm), 1);
    @(negedge clk);
    chk(pwm == 1'b1, "R5", int'(pwm), 1);
    per = exp_per(hz, sel);
    h1  = per * exp_eff(d1, md, tm) / 255;
    h2  = per * exp_eff(d2, md, tm) / 255;
    @(negedge clk);
    chk(rb == d1, "R10", rb, d1);
    chk(pwm == (h1 > 0), "R2", int'(pwm), int'(h1 > 0));
    duty = d2;
    cnt = 0;
    for (int k = 0; k < per; k++) begin
      if (k > 0) @(negedge clk);
      cnt += int'(pwm);
      if (k == per - 1) begin
        chk(pwm == (h1 == per), "R2", int'(pwm), int'(h1 == per));
        chk(rb == d1, "R4", rb, d1);
      end
    end
    chk(cnt == h1, tag, cnt, h1);
    cnt = 0;
    for (int k = 0; k < per; k++) begin
      @(negedge clk);
      cnt += int'(pwm);
      if (k == 0) begin
        chk(rb == d2, "R4", rb, d2);
        chk(pwm == (h2 > 0), "R2", int'(pwm), int'(h2 > 0));
      end
    end
    chk(cnt == h2, "R4", cnt, h2);
  endtask

  initial begin
    #(190_000 * 8);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk);
    chk(pwm == 1'b0, "R1", int'(pwm), 0);
    chk(rb == 8'h55, "R1", rb, 8'h55);
    rst_n = 1;

    // R3 exhaustive duty sweep, no clamp, 40 kHz
    for (int d = 0; d < 256; d++)
      run_per(8'(d), 8'(255 - d), 2'd0, 1'b1, 1'b0, 3'd5, "R3");

    // R2 kilohertz range, every code
    for (int s = 0; s < 8; s++)
      run_per(8'h80, 8'h40, 2'd0, 1'b1, 1'b0, 3'(s), "R2");
    // R2 hertz range, fastest code
    run_per(8'hC0, 8'h80, 2'd0, 1'b1, 1'b1, 3'd7, "R2");

    // R7 / R8 clamp boundaries, every mode, tach-mode 0
    for (int m = 0; m < 4; m++) begin
      int codes [7] = '{0, 17, 18, 76, 77, 78, 200};
      for (int i = 0; i < 7; i++)
        run_per(8'(codes[i]), 8'(codes[i]), 2'(m), 1'b0, 1'b0, 3'd5, (m == 1) ? "R7" : "R8");
    end
    // R9 tach-mode 1 disables clamps
    run_per(8'd0, 8'd17, 2'd1, 1'b1, 1'b0, 3'd5, "R9");
    run_per(8'd10, 8'd60, 2'd1, 1'b1, 1'b0, 3'd5, "R9");
    run_per(8'd17, 8'd5, 2'd2, 1'b1, 1'b0, 3'd5, "R9");

    // R5 spin-up length per code
    for (int c = 0; c < 8; c++) begin
      int cnt;
      @(negedge clk);
      duty = 8'd0; mode = 2'd0; tach = 1'b1; sdis = 0; stime = 3'(c); start = 1;
      @(negedge clk);
      start = 0;
      cnt = 0;
      while (pwm && cnt < 200) begin
        cnt++;
        @(negedge clk);
      end
      chk(cnt == exp_units(c) * UNIT, "R5", cnt, exp_units(c) * UNIT);
    end

    // R6 disabled spin-up ignores start
    @(negedge clk);
    sdis = 1; stime = 3'd7; start = 1;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < 12; i++) begin
      chk(pwm == 1'b0, "R6", int'(pwm), 0);
      @(negedge clk);
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule